// File: doc/BRIEF.md
# Operand Address Resolver

This block turns one operand specifier of a 16-bit two-address processor into either a "the register is the operand" indication or a final 16-bit operand address. The processor has eight general registers. Register 6 is the conventional stack pointer and register 7 is the program counter. A specifier is a 3-bit addressing mode, a 3-bit register number and a byte/word flag. While it resolves the specifier, the block applies any post-increment or pre-decrement to the register. It also fetches an index word from the instruction stream and makes the indirect memory read when the mode calls for one.

A sequencer accepts a `start` pulse while idle and latches the specifier. It reads and updates registers through a register-file port. The port has a combinational read and a write that takes effect on the clock edge. Memory reads go through a word-read port: a request is held, with its address held steady, until an acknowledge arrives. When the result is ready, `done` pulses for one cycle. `addr` and `is_reg` then hold their values until the next specifier is accepted.

Top module: `opspec_resolver`

## Requirements
- R1: Mode 0 completes with `is_reg`=1 and `addr`=0. It makes no memory read and writes no register.
- R2: Mode 1 returns the register value as `addr` and leaves the register unchanged.
- R3: Mode 2 returns the old register value as `addr`. It then adds 1 to the register for a byte operand (`byte_op`=1) and 2 for a word operand.
- R4: Mode 4 subtracts 1 (byte) or 2 (word) from the register and returns the new value as `addr`. The arithmetic wraps modulo 2^16.
- R5: In modes 2 and 4, when the register is 6 or 7, the step is 2 even for a byte operand.
- R6: Mode 3 reads the word at the register value and returns that word as `addr`. It adds 2 to the register whatever the operand size.
- R7: Mode 5 subtracts 2 from the register, reads the word at the new value, and returns that word as `addr`.
- R8: Mode 6 reads the index word X at the address in register 7 and adds 2 to register 7. It then returns (register + X) mod 2^16, using the updated register 7 when the selected register is 7.
- R9: Mode 7 forms the same sum as mode 6, reads the word at that sum, and returns the word as `addr`. It makes exactly two memory reads.
- R10: `busy` is high from the cycle after an accepted `start` until `done`. `done` is a one-cycle pulse while `busy` is low. A `start` that arrives while busy is ignored. Modes 0, 1, 2 and 4 raise `done` two cycles after the start edge.
- R11: `mem_req` is raised only while busy. It stays high, with `mem_addr` stable, until a cycle in which `mem_ack` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin resolving a specifier (taken only when idle) |
| mode | input | 3 | Addressing mode 0..7 |
| regsel | input | 3 | Register number |
| byte_op | input | 1 | 1 = byte operand, 0 = word operand |
| busy | output | 1 | Resolution in progress |
| done | output | 1 | One-cycle completion pulse |
| is_reg | output | 1 | Operand is the register itself |
| addr | output | 16 | Resolved operand address |
| reg_raddr | output | 3 | Register-file read select |
| reg_rdata | input | 16 | Register-file read data (combinational) |
| reg_we | output | 1 | Register-file write enable |
| reg_waddr | output | 3 | Register-file write select |
| reg_wdata | output | 16 | Register-file write data |
| mem_req | output | 1 | Memory word-read request |
| mem_addr | output | 16 | Memory read address |
| mem_ack | input | 1 | Memory acknowledge; data valid this cycle |
| mem_rdata | input | 16 | Memory read data |

## Verification
A wrong latched mode or a wrong sequencer state shows up in the `done` cycle. It appears as a wrong address or `is_reg`, as an unexpected number of memory transfers, or as completion at the wrong cycle count. These effects are visible at most one memory transfer after the fault. A wrong step size or direction leaves the register file holding a value other than old ±1 or ±2 on the edge where `reg_we` is high. For the index modes, a program counter that is updated at the wrong time shifts the sum by exactly 2 for register 7.

// File: rtl/opspec_pkg.sv
package opspec_pkg;

    parameter int unsigned OPW    = 16;
    parameter int unsigned NREG   = 8;
    parameter int unsigned RSEL_W = $clog2(NREG);
    parameter int unsigned MODE_W = 3;

    typedef enum logic [MODE_W-1:0] {
        M_REG    = 3'd0,
        M_DEF    = 3'd1,
        M_INC    = 3'd2,
        M_INCDEF = 3'd3,
        M_DEC    = 3'd4,
        M_DECDEF = 3'd5,
        M_IDX    = 3'd6,
        M_IDXDEF = 3'd7
    } addr_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_EVAL,
        ST_INDEX,
        ST_SUM,
        ST_DEFER,
        ST_FIN
    } seq_state_e;

    typedef struct packed {
        seq_state_e           state;
        addr_mode_e           mode;
        logic [RSEL_W-1:0]    rsel;
        logic                 byte_op;
        logic [OPW-1:0]       ptr;
        logic [OPW-1:0]       xword;
        logic [OPW-1:0]       addr;
        logic                 is_reg;
    } seq_regs_t;

endpackage

// File: rtl/opspec_step.sv
module opspec_step
    import opspec_pkg::*;
#(
    parameter logic [RSEL_W-1:0] SP_IDX = RSEL_W'(6),
    parameter logic [RSEL_W-1:0] PC_IDX = RSEL_W'(7)
) (
    input  addr_mode_e          mode_i,
    input  logic [RSEL_W-1:0]   rsel_i,
    input  logic                byte_i,
    output logic [OPW-1:0]      step_o,
    output logic                down_o
);
    localparam logic [OPW-1:0] STEP_ONE = OPW'(1);
    localparam logic [OPW-1:0] STEP_TWO = OPW'(2);

    logic deferred;
    logic word_step;

    always_comb begin
        deferred  = (mode_i == M_INCDEF) || (mode_i == M_DECDEF);
        word_step = deferred || !byte_i || (rsel_i == SP_IDX) || (rsel_i == PC_IDX);
        step_o    = word_step ? STEP_TWO : STEP_ONE;
        down_o    = (mode_i == M_DEC) || (mode_i == M_DECDEF);
    end
endmodule

// File: rtl/opspec_addsub.sv
module opspec_addsub
    import opspec_pkg::*;
(
    input  logic [OPW-1:0] a_i,
    input  logic [OPW-1:0] b_i,
    input  logic           sub_i,
    output logic [OPW-1:0] y_o
);
    always_comb begin
        y_o = sub_i ? (a_i - b_i) : (a_i + b_i);
    end
endmodule

// File: rtl/opspec_resolver.sv
module opspec_resolver
    import opspec_pkg::*;
#(
    parameter logic [RSEL_W-1:0] SP_IDX = RSEL_W'(6),
    parameter logic [RSEL_W-1:0] PC_IDX = RSEL_W'(7)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [MODE_W-1:0] mode,
    input  logic [RSEL_W-1:0] regsel,
    input  logic              byte_op,
    output logic              busy,
    output logic              done,
    output logic              is_reg,
    output logic [OPW-1:0]    addr,
    output logic [RSEL_W-1:0] reg_raddr,
    input  logic [OPW-1:0]    reg_rdata,
    output logic              reg_we,
    output logic [RSEL_W-1:0] reg_waddr,
    output logic [OPW-1:0]    reg_wdata,
    output logic              mem_req,
    output logic [OPW-1:0]    mem_addr,
    input  logic              mem_ack,
    input  logic [OPW-1:0]    mem_rdata
);
    localparam logic [OPW-1:0] PC_ADVANCE = OPW'(2);

    seq_regs_t      cur_q, nxt_d;
    logic [OPW-1:0] step_amt;
    logic           step_down;
    logic [OPW-1:0] stepped;
    logic [OPW-1:0] sum_b;
    logic [OPW-1:0] sum_y;

    opspec_step #(.SP_IDX(SP_IDX), .PC_IDX(PC_IDX)) u_step (
        .mode_i (cur_q.mode),
        .rsel_i (cur_q.rsel),
        .byte_i (cur_q.byte_op),
        .step_o (step_amt),
        .down_o (step_down)
    );

    opspec_addsub u_stepadd (
        .a_i   (reg_rdata),
        .b_i   (step_amt),
        .sub_i (step_down),
        .y_o   (stepped)
    );

    opspec_addsub u_sumadd (
        .a_i   (reg_rdata),
        .b_i   (sum_b),
        .sub_i (1'b0),
        .y_o   (sum_y)
    );

    always_comb begin
        nxt_d     = cur_q;
        reg_raddr = cur_q.rsel;
        reg_we    = 1'b0;
        reg_waddr = cur_q.rsel;
        reg_wdata = stepped;
        mem_req   = 1'b0;
        mem_addr  = cur_q.ptr;
        sum_b     = cur_q.xword;

        unique case (cur_q.state)
            ST_IDLE: begin
                if (start) begin
                    nxt_d.state   = ST_EVAL;
                    nxt_d.mode    = addr_mode_e'(mode);
                    nxt_d.rsel    = regsel;
                    nxt_d.byte_op = byte_op;
                    nxt_d.is_reg  = 1'b0;
                    nxt_d.addr    = '0;
                end
            end
            ST_EVAL: begin
                unique case (cur_q.mode)
                    M_REG: begin
                        nxt_d.is_reg = 1'b1;
                        nxt_d.state  = ST_FIN;
                    end
                    M_DEF: begin
                        nxt_d.addr  = reg_rdata;
                        nxt_d.state = ST_FIN;
                    end
                    M_INC: begin
                        nxt_d.addr  = reg_rdata;
                        reg_we      = 1'b1;
                        nxt_d.state = ST_FIN;
                    end
                    M_INCDEF: begin
                        nxt_d.ptr   = reg_rdata;
                        reg_we      = 1'b1;
                        nxt_d.state = ST_DEFER;
                    end
                    M_DEC: begin
                        nxt_d.addr  = stepped;
                        reg_we      = 1'b1;
                        nxt_d.state = ST_FIN;
                    end
                    M_DECDEF: begin
                        nxt_d.ptr   = stepped;
                        reg_we      = 1'b1;
                        nxt_d.state = ST_DEFER;
                    end
                    M_IDX, M_IDXDEF: begin
                        nxt_d.state = ST_INDEX;
                    end
                endcase
            end
            ST_INDEX: begin
                reg_raddr = PC_IDX;
                mem_req   = 1'b1;
                mem_addr  = reg_rdata;
                sum_b     = PC_ADVANCE;
                if (mem_ack) begin
                    nxt_d.xword = mem_rdata;
                    reg_we      = 1'b1;
                    reg_waddr   = PC_IDX;
                    reg_wdata   = sum_y;
                    nxt_d.state = ST_SUM;
                end
            end
            ST_SUM: begin
                if (cur_q.mode == M_IDX) begin
                    nxt_d.addr  = sum_y;
                    nxt_d.state = ST_FIN;
                end else begin
                    nxt_d.ptr   = sum_y;
                    nxt_d.state = ST_DEFER;
                end
            end
            ST_DEFER: begin
                mem_req = 1'b1;
                if (mem_ack) begin
                    nxt_d.addr  = mem_rdata;
                    nxt_d.state = ST_FIN;
                end
            end
            ST_FIN: begin
                nxt_d.state = ST_IDLE;
            end
            default: begin
                nxt_d.state = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_IDLE, mode: M_REG, default: '0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign busy   = (cur_q.state != ST_IDLE) && (cur_q.state != ST_FIN);
    assign done   = (cur_q.state == ST_FIN);
    assign is_reg = cur_q.is_reg;
    assign addr   = cur_q.addr;
endmodule

// File: rtl/opspec_resolver_chk.sv
module opspec_resolver_chk
    import opspec_pkg::*;
#(
    parameter logic [RSEL_W-1:0] SP_IDX = RSEL_W'(6),
    parameter logic [RSEL_W-1:0] PC_IDX = RSEL_W'(7)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              is_reg,
    input logic [OPW-1:0]    addr,
    input logic [RSEL_W-1:0] reg_raddr,
    input logic [OPW-1:0]    reg_rdata,
    input logic              reg_we,
    input logic [RSEL_W-1:0] reg_waddr,
    input logic [OPW-1:0]    reg_wdata,
    input logic              mem_req,
    input logic [OPW-1:0]    mem_addr,
    input logic              mem_ack
);
    logic [OPW-1:0] delta;
    assign delta = reg_wdata - reg_rdata;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R10

    AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy); // R10

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && !done) |=> busy); // R10

    AST_REG_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (done && is_reg) |-> (addr == '0)); // R1

    AST_REQ_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy); // R11

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr))); // R11

    AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> busy); // R10

    AST_WE_SMALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> ((reg_waddr == reg_raddr) &&
                     ((delta == OPW'(1)) || (delta == OPW'(2)) ||
                      (delta == {OPW{1'b1}}) || (delta == ({OPW{1'b1}} - OPW'(1)))))); // R3

    AST_WE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && ((reg_waddr == SP_IDX) || (reg_waddr == PC_IDX)) && !reg_rdata[0])
            |-> !reg_wdata[0]); // R5
endmodule

bind opspec_resolver opspec_resolver_chk #(.SP_IDX(SP_IDX), .PC_IDX(PC_IDX)) u_chk (.*);

// File: tb/opspec_resolver_bench.sv
`timescale 1ns/1ps
module opspec_resolver_bench;
    import opspec_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [2:0]        mode = '0;
    logic [2:0]        regsel = '0;
    logic              byte_op = 1'b0;
    logic              busy, done, is_reg;
    logic [15:0]       addr;
    logic [2:0]        reg_raddr, reg_waddr;
    logic [15:0]       reg_rdata, reg_wdata;
    logic              reg_we;
    logic              mem_req;
    logic [15:0]       mem_addr;
    logic              mem_ack = 1'b0;
    logic [15:0]       mem_rdata = '0;

    logic [15:0] regs [8];
    int n_chk = 0;
    int n_fail = 0;
    int cur_lat = 0;
    int wait_cnt = 0;
    int xfer_cnt = 0;
    logic [15:0] first_xfer = '0;

    always #10 clk = ~clk;

    opspec_resolver u_opspec_resolver (
        .clk, .rst_n, .start, .mode, .regsel, .byte_op,
        .busy, .done, .is_reg, .addr,
        .reg_raddr, .reg_rdata, .reg_we, .reg_waddr, .reg_wdata,
        .mem_req, .mem_addr, .mem_ack, .mem_rdata
    );

    assign reg_rdata = regs[reg_raddr];

    always @(posedge clk) begin
        if (reg_we) regs[reg_waddr] <= reg_wdata;
    end

    // Memory model: word at address a reads as ~a, acknowledged after cur_lat waits.
    always @(negedge clk) begin
        if (mem_req && !mem_ack) begin
            if (wait_cnt >= cur_lat) begin
                mem_ack   = 1'b1;
                mem_rdata = ~mem_addr;
                xfer_cnt  = xfer_cnt + 1;
                if (xfer_cnt == 1) first_xfer = mem_addr;
                wait_cnt  = 0;
            end else begin
                wait_cnt = wait_cnt + 1;
            end
        end else begin
            mem_ack = 1'b0;
        end
    end

    typedef struct packed {
        logic [2:0]  vmode;
        logic [2:0]  vrsel;
        logic        vbyte;
        logic [1:0]  vlat;
        logic [15:0] rv;
        logic [15:0] pc;
        logic [15:0] exp_addr;
        logic [15:0] exp_r;
        logic [15:0] exp_pc;
        logic        exp_isreg;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 3'd1, 1'b0, 2'd0, 16'h1234, 16'h0100, 16'h0000, 16'h1234, 16'h0100, 1'b1},
        '{3'd1, 3'd2, 1'b0, 2'd0, 16'h2000, 16'h0100, 16'h2000, 16'h2000, 16'h0100, 1'b0},
        '{3'd2, 3'd3, 1'b1, 2'd0, 16'h3001, 16'h0100, 16'h3001, 16'h3002, 16'h0100, 1'b0},
        '{3'd2, 3'd3, 1'b0, 2'd0, 16'h3000, 16'h0100, 16'h3000, 16'h3002, 16'h0100, 1'b0},
        '{3'd2, 3'd6, 1'b1, 2'd0, 16'h4000, 16'h0100, 16'h4000, 16'h4002, 16'h0100, 1'b0},
        '{3'd4, 3'd4, 1'b1, 2'd0, 16'h5005, 16'h0100, 16'h5004, 16'h5004, 16'h0100, 1'b0},
        '{3'd4, 3'd4, 1'b0, 2'd0, 16'h0000, 16'h0100, 16'hFFFE, 16'hFFFE, 16'h0100, 1'b0},
        '{3'd4, 3'd6, 1'b1, 2'd0, 16'h6000, 16'h0100, 16'h5FFE, 16'h5FFE, 16'h0100, 1'b0},
        '{3'd3, 3'd1, 1'b1, 2'd2, 16'h1000, 16'h0100, 16'hEFFF, 16'h1002, 16'h0100, 1'b0},
        '{3'd5, 3'd2, 1'b1, 2'd1, 16'h2002, 16'h0100, 16'hDFFF, 16'h2000, 16'h0100, 1'b0},
        '{3'd6, 3'd3, 1'b0, 2'd1, 16'h0010, 16'h0200, 16'hFE0F, 16'h0010, 16'h0202, 1'b0},
        '{3'd6, 3'd7, 1'b0, 2'd0, 16'h0300, 16'h0300, 16'h0001, 16'h0302, 16'h0302, 1'b0},
        '{3'd7, 3'd5, 1'b0, 2'd0, 16'h0020, 16'h0400, 16'h03E0, 16'h0020, 16'h0402, 1'b0},
        '{3'd2, 3'd7, 1'b1, 2'd3, 16'h0500, 16'h0500, 16'h0500, 16'h0502, 16'h0502, 1'b0}
    };

    function automatic string req_of(input logic [2:0] m, input logic [2:0] r, input logic b);
        case (m)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return (b && r >= 3'd6) ? "R5" : "R3";
            3'd3: return "R6";
            3'd4: return (b && r >= 3'd6) ? "R5" : "R4";
            3'd5: return "R7";
            3'd6: return "R8";
            default: return "R9";
        endcase
    endfunction

    function automatic logic [15:0] fill_of(input int i);
        return 16'hA000 + 16'(i) * 16'h0111;
    endfunction

    task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic load_regs(input vec_t v);
        for (int i = 0; i < 8; i++) regs[i] = fill_of(i);
        regs[7] = v.pc;
        regs[v.vrsel] = v.rv;
    endtask

    // Drive one start pulse and wait for done; returns cycles and whether busy held.
    task automatic run_op(input logic [2:0] m, input logic [2:0] r, input logic b,
                          output int cycles, output logic busy_ok);
        @(negedge clk);
        mode = m; regsel = r; byte_op = b; start = 1'b1;
        xfer_cnt = 0; wait_cnt = 0;
        cycles = 0; busy_ok = 1'b1;
        forever begin
            @(negedge clk);
            start = 1'b0;
            cycles++;
            if (done) break;
            if (!busy) busy_ok = 1'b0;
            if (cycles > 60) begin
                chk("R10", "watchdog waiting for done", 16'(cycles), 16'd0);
                break;
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL R10 global watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int cyc;
        logic bok;
        for (int i = 0; i < 8; i++) regs[i] = '0;
        repeat (3) @(negedge clk);
        // Reset state
        chk("R10", "busy in reset", {15'd0, busy}, 16'd0);
        chk("R10", "done in reset", {15'd0, done}, 16'd0);
        chk("R11", "mem_req in reset", {15'd0, mem_req}, 16'd0);
        chk("R1", "reg_we in reset", {15'd0, reg_we}, 16'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10", "busy after reset", {15'd0, busy}, 16'd0);

        for (int k = 0; k < NV; k++) begin
            vec_t v;
            string rq;
            int exp_x;
            v = VEC[k];
            rq = req_of(v.vmode, v.vrsel, v.vbyte);
            cur_lat = int'(v.vlat);
            load_regs(v);
            run_op(v.vmode, v.vrsel, v.vbyte, cyc, bok);
            chk(rq, $sformatf("vec %0d addr", k), addr, v.exp_addr);
            chk(rq, $sformatf("vec %0d is_reg", k), {15'd0, is_reg}, {15'd0, v.exp_isreg});
            chk("R10", $sformatf("vec %0d busy until done", k), {15'd0, bok}, 16'd1);
            case (v.vmode)
                3'd3, 3'd5, 3'd6: exp_x = 1;
                3'd7: exp_x = 2;
                default: exp_x = 0;
            endcase
            chk(rq, $sformatf("vec %0d memory reads", k), 16'(xfer_cnt), 16'(exp_x));
            if (v.vmode == 3'd6 || v.vmode == 3'd7)
                chk("R8", $sformatf("vec %0d index fetch address", k), first_xfer, v.pc);
            if (v.vmode == 3'd0 || v.vmode == 3'd1 || v.vmode == 3'd2 || v.vmode == 3'd4)
                chk("R10", $sformatf("vec %0d cycles to done", k), 16'(cyc), 16'd2);
            @(negedge clk);
            chk(rq, $sformatf("vec %0d register after", k), regs[v.vrsel], v.exp_r);
            chk(rq, $sformatf("vec %0d pc after", k), regs[7], v.exp_pc);
            for (int j = 0; j < 7; j++) begin
                if (j != int'(v.vrsel))
                    chk(rq, $sformatf("vec %0d other reg %0d untouched", k, j), regs[j], fill_of(j));
            end
            chk("R10", $sformatf("vec %0d addr held after done", k), addr, v.exp_addr);
        end

        // Start while busy is ignored (R10)
        begin
            vec_t v;
            int extra_done;
            v = VEC[10];
            cur_lat = 3;
            load_regs(v);
            @(negedge clk);
            mode = 3'd6; regsel = 3'd3; byte_op = 1'b0; start = 1'b1;
            xfer_cnt = 0; wait_cnt = 0;
            @(negedge clk);
            mode = 3'd0; regsel = 3'd1; start = 1'b1;
            chk("R10", "busy during second start", {15'd0, busy}, 16'd1);
            @(negedge clk);
            start = 1'b0;
            cyc = 0;
            while (!done && cyc < 60) begin
                @(negedge clk);
                cyc++;
            end
            chk("R10", "ignored start addr", addr, 16'hFE0F);
            chk("R10", "ignored start is_reg", {15'd0, is_reg}, 16'd0);
            extra_done = 0;
            for (int t = 0; t < 5; t++) begin
                @(negedge clk);
                if (done || busy) extra_done++;
            end
            chk("R10", "no second operation", 16'(extra_done), 16'd0);
            chk("R11", "single index fetch", 16'(xfer_cnt), 16'd1);
        end

        finish_run();
    end
endmodule